// File: doc/BRIEF.md
# Three-Wire Potentiometer Step Sequencer

This block sits on the host side of a digital potentiometer that has three control lines: an active-low select, a step strobe whose falling edge moves the wiper, and a direction level. A client gives it a command that holds a direction, a step count and a flag that says whether the final wiper setting is committed to the part's nonvolatile memory. The sequencer then drives the three lines with every setup time, pulse width and deselect time met. Each of those times is a parameter in system clock cycles. By default each one is rounded up from its nanosecond minimum and the clock frequency.

The commit decision is carried only by the strobe level at the moment select is released. If the strobe is high, the part stores the setting, and a long quiet time must follow. If the strobe is low, no store happens, and only a short quiet time is needed. The block keeps an estimate of the wiper tap. The estimate moves by one on each strobe fall and clamps at both ends of the travel.

The command side uses a ready/valid handshake. A one-cycle completion pulse follows each command once its quiet time has passed.

Top module: `pot3w_driver`

## Requirements
- R1: `cmd_ready_o` is high only while idle. While idle, `cs_no` and `inc_o` are both high. A command is taken on a rising edge where `cmd_valid_i` and `cmd_ready_o` are both high, and `cmd_ready_o` stays low while `cs_no` is low.
- R2: When a command that touches the pins is taken, `cs_no` falls on that same edge. `dir_o` takes `cmd_up_i` (1 = toward the top end, 0 = toward zero) and keeps it while `cs_no` is low. The first `inc_o` fall comes T_SEL = max(T_CS_SETUP, T_DIR_SETUP) cycles after `cs_no` falls.
- R3: While selected, `inc_o` falls exactly `cmd_steps_i` times. Each low phase that is followed by a rise lasts T_INC_LOW cycles. Each high phase between two falls lasts T_HI = max(T_INC_HIGH, T_CYC - T_INC_LOW) cycles.
- R4: Store ending (store flag 1, steps > 0): `inc_o` rises after the last fall. `cs_no` rises T_HI + T_PRE_DESEL cycles after that rise, with `inc_o` high. `done_o` rises T_STORE_WAIT cycles after `cs_no` rises.
- R5: No-store ending (store flag 0, steps > 0): the last fall is not followed by a rise while selected. `cs_no` rises T_LAST_LOW = max(T_INC_LOW, T_PRE_DESEL) cycles after the last fall. `inc_o` rises T_NOSTORE_WAIT cycles after `cs_no` rises. `done_o` rises T_REARM = max(T_DIR_HOLD, T_INC_HIGH) cycles after that.
- R6: Pure store (steps 0, store flag 1): there is no `inc_o` edge. `cs_no` is low for T_SEL + T_PRE_DESEL cycles. `done_o` rises T_STORE_WAIT cycles after `cs_no` rises.
- R7: Steps 0 with store flag 0 completes with no edge on `cs_no` or `inc_o`.
- R8: `done_o` is a single-cycle pulse, given exactly once per command.
- R9: `pos_o` resets to 0. It moves by +1 (up) or -1 (down) on each `inc_o` fall and saturates at 0 and POS_MAX (99 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle, command can be taken |
| cmd_up_i | input | 1 | Direction: 1 up, 0 down |
| cmd_steps_i | input | STEP_W | Number of strobe falls |
| cmd_store_i | input | 1 | 1 commits the final setting to nonvolatile memory |
| done_o | output | 1 | One-cycle completion pulse |
| cs_no | output | 1 | Potentiometer select, active low |
| inc_o | output | 1 | Step strobe, falling edge moves the wiper |
| dir_o | output | 1 | Direction level to the potentiometer |
| pos_o | output | POS_W | Estimated wiper tap |

## Verification
The hardest condition to reach is the clamp of the position estimate at the top end while steps are still being issued. The no-store ending, where the final fall is never followed by a rise while selected, is hard to reach for the same reason. The bench uses a small configuration with POS_MAX of 9 and step counts up to 15. It sweeps every step count in both directions under both endings, so the estimate hits and holds at both ends many times. Every edge of the three lines is timed and compared against durations computed from the requirement formulas.

// File: rtl/pot3w_pkg.sv
package pot3w_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SEL, S_LOW, S_HIGH, S_HOLD, S_WAIT, S_REARM, S_DONE
  } pot3w_state_e;

  function automatic int ns2cyc(input longint ns, input longint clk_khz);
    return int'((ns * clk_khz + 64'd999_999) / 64'd1_000_000);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pot3w_timer.sv
module pot3w_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  // loaded with N keeps the owning state for N cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i - CNT_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pot3w_pos.sv
module pot3w_pos #(
  parameter int POS_MAX = 99,
  parameter int POS_W   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             up_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] TOP = POS_W'(POS_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_o <= '0;
    else if (step_i) begin
      if (up_i && pos_o != TOP)      pos_o <= pos_o + POS_W'(1);
      else if (!up_i && pos_o != '0) pos_o <= pos_o - POS_W'(1);
    end
  end
endmodule

// File: rtl/pot3w_seq.sv
module pot3w_seq import pot3w_pkg::*; #(
  parameter int STEP_W         = 7,
  parameter int CNT_W          = 8,
  parameter int T_SEL          = 1,
  parameter int T_INC_LOW      = 1,
  parameter int T_HI           = 1,
  parameter int T_LAST_LOW     = 1,
  parameter int T_PRE_DESEL    = 1,
  parameter int T_STORE_WAIT   = 1,
  parameter int T_NOSTORE_WAIT = 1,
  parameter int T_REARM        = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_up_i,
  input  logic [STEP_W-1:0] cmd_steps_i,
  input  logic              cmd_store_i,
  output logic              cmd_ready_o,
  input  logic              tmr_zero_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              step_o,
  output logic              cs_no,
  output logic              inc_o,
  output logic              dir_o,
  output logic              done_o
);
  pot3w_state_e st_q, st_d;
  logic [STEP_W-1:0] rem_q, rem_d;
  logic store_q, store_d, cs_d, inc_d, dir_d, fall;

  always_comb begin
    st_d = st_q; rem_d = rem_q; store_d = store_q;
    cs_d = cs_no; inc_d = inc_o; dir_d = dir_o;
    tmr_load_o = 1'b0; tmr_val_o = '0; fall = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_valid_i) begin
        dir_d = cmd_up_i; store_d = cmd_store_i; rem_d = cmd_steps_i;
        if (cmd_steps_i == '0 && !cmd_store_i) st_d = S_DONE;
        else begin
          cs_d = 1'b0; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(T_SEL); st_d = S_SEL;
        end
      end
      S_SEL, S_HIGH: if (tmr_zero_i) begin
        if (rem_q == '0) begin
          tmr_load_o = 1'b1; tmr_val_o = CNT_W'(T_PRE_DESEL); st_d = S_HOLD;
        end else fall = 1'b1;
      end
      S_LOW: if (tmr_zero_i) begin
        inc_d = 1'b1; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(T_HI); st_d = S_HIGH;
      end
      S_HOLD: if (tmr_zero_i) begin
        cs_d = 1'b1; tmr_load_o = 1'b1;
        tmr_val_o = store_q ? CNT_W'(T_STORE_WAIT) : CNT_W'(T_NOSTORE_WAIT);
        st_d = S_WAIT;
      end
      S_WAIT: if (tmr_zero_i) begin
        if (!inc_o) begin
          inc_d = 1'b1; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(T_REARM); st_d = S_REARM;
        end else st_d = S_DONE;
      end
      S_REARM: if (tmr_zero_i) st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (fall) begin
      inc_d = 1'b0; rem_d = rem_q - STEP_W'(1); tmr_load_o = 1'b1;
      // last step without store: strobe stays low through deselect
      if (rem_q == STEP_W'(1) && !store_q) begin
        tmr_val_o = CNT_W'(T_LAST_LOW); st_d = S_HOLD;
      end else begin
        tmr_val_o = CNT_W'(T_INC_LOW); st_d = S_LOW;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; rem_q <= '0; store_q <= 1'b0;
      cs_no <= 1'b1; inc_o <= 1'b1; dir_o <= 1'b0;
    end else begin
      st_q <= st_d; rem_q <= rem_d; store_q <= store_d;
      cs_no <= cs_d; inc_o <= inc_d; dir_o <= dir_d;
    end
  end

  assign step_o      = fall;
  assign cmd_ready_o = (st_q == S_IDLE);
  assign done_o      = (st_q == S_DONE);
endmodule

// File: rtl/pot3w_driver.sv
module pot3w_driver import pot3w_pkg::*; #(
  parameter int CLK_KHZ        = 50_000,
  parameter int POS_MAX        = 99,
  parameter int STEP_W         = 7,
  parameter int T_CS_SETUP     = ns2cyc(100, CLK_KHZ),
  parameter int T_DIR_SETUP    = ns2cyc(2_900, CLK_KHZ),
  parameter int T_INC_LOW      = ns2cyc(1_000, CLK_KHZ),
  parameter int T_INC_HIGH     = ns2cyc(1_000, CLK_KHZ),
  parameter int T_CYC          = ns2cyc(4_000, CLK_KHZ),
  parameter int T_DIR_HOLD     = ns2cyc(100, CLK_KHZ),
  parameter int T_PRE_DESEL    = ns2cyc(1_000, CLK_KHZ),
  parameter int T_STORE_WAIT   = ns2cyc(20_000_000, CLK_KHZ),
  parameter int T_NOSTORE_WAIT = ns2cyc(100, CLK_KHZ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_up_i,
  input  logic [STEP_W-1:0] cmd_steps_i,
  input  logic              cmd_store_i,
  output logic              done_o,
  output logic              cs_no,
  output logic              inc_o,
  output logic              dir_o,
  output logic [$clog2(POS_MAX+1)-1:0] pos_o
);
  localparam int POS_W      = $clog2(POS_MAX + 1);
  localparam int T_SEL      = imax(T_CS_SETUP, T_DIR_SETUP);
  localparam int T_HI       = imax(T_INC_HIGH, T_CYC - T_INC_LOW);
  localparam int T_LAST_LOW = imax(T_INC_LOW, T_PRE_DESEL);
  localparam int T_REARM    = imax(T_DIR_HOLD, T_INC_HIGH);
  localparam int T_MAX      = imax(imax(imax(T_SEL, T_HI), imax(T_LAST_LOW, T_REARM)),
                                   imax(T_STORE_WAIT, T_NOSTORE_WAIT));
  localparam int CNT_W      = $clog2(T_MAX + 1);

  logic tmr_load, tmr_zero, step;
  logic [CNT_W-1:0] tmr_val;

  pot3w_seq #(
    .STEP_W(STEP_W), .CNT_W(CNT_W), .T_SEL(T_SEL), .T_INC_LOW(T_INC_LOW),
    .T_HI(T_HI), .T_LAST_LOW(T_LAST_LOW), .T_PRE_DESEL(T_PRE_DESEL),
    .T_STORE_WAIT(T_STORE_WAIT), .T_NOSTORE_WAIT(T_NOSTORE_WAIT), .T_REARM(T_REARM)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_up_i(cmd_up_i),
    .cmd_steps_i(cmd_steps_i), .cmd_store_i(cmd_store_i), .cmd_ready_o(cmd_ready_o),
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .step_o(step),
    .cs_no(cs_no), .inc_o(inc_o), .dir_o(dir_o), .done_o(done_o)
  );

  pot3w_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  pot3w_pos #(.POS_MAX(POS_MAX), .POS_W(POS_W)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .up_i(dir_o), .pos_o(pos_o)
  );
endmodule

// File: rtl/pot3w_chk.sv
module pot3w_chk #(
  parameter int POS_MAX   = 99,
  parameter int POS_W     = 7,
  parameter int T_INC_LOW = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_ready_o,
  input logic             done_o,
  input logic             cs_no,
  input logic             inc_o,
  input logic             dir_o,
  input logic [POS_W-1:0] pos_o
);
  logic inc_prev;
  logic [31:0] run_q;

  // length of the current strobe level run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_prev <= 1'b1; run_q <= '0;
    end else begin
      inc_prev <= inc_o;
      if (inc_o != inc_prev)   run_q <= 32'd1;
      else if (run_q != '1)    run_q <= run_q + 32'd1;
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (cs_no && inc_o)); // R1
  AST_DIR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(dir_o)); // R2
  AST_INC_LOW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_o && !inc_prev && !cs_no) |-> (run_q >= 32'(T_INC_LOW))); // R3
  AST_CS_RISE_INC_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> $stable(inc_o)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o <= POS_W'(POS_MAX)); // R9
  AST_POS_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pos_o) |-> ($fell(inc_o) && !cs_no)); // R9
endmodule

bind pot3w_driver pot3w_chk #(.POS_MAX(POS_MAX), .POS_W(POS_W), .T_INC_LOW(T_INC_LOW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o), .done_o(done_o),
  .cs_no(cs_no), .inc_o(inc_o), .dir_o(dir_o), .pos_o(pos_o)
);

// File: tb/sim_pot3w_driver.sv
`timescale 1ns/1ps
module sim_pot3w_driver;
  localparam int PMAX = 9, SW = 4;
  localparam int CSU = 2, DSU = 3, ILO = 2, IHI = 2, CYC = 5, DHO = 1, PRE = 3, SWT = 20, NSW = 2;
  localparam int SEL   = (CSU > DSU) ? CSU : DSU;
  localparam int HI    = (IHI > CYC - ILO) ? IHI : CYC - ILO;
  localparam int LLOW  = (ILO > PRE) ? ILO : PRE;
  localparam int REARM = (DHO > IHI) ? DHO : IHI;
  localparam int PW = $clog2(PMAX + 1);

  logic clk = 0, rst_n = 0;
  logic valid = 0, up = 0, store = 0;
  logic [SW-1:0] steps = '0;
  logic ready, done, cs_n, inc, dir;
  logic [PW-1:0] pos;

  always #10 clk = ~clk;

  pot3w_driver #(
    .POS_MAX(PMAX), .STEP_W(SW), .T_CS_SETUP(CSU), .T_DIR_SETUP(DSU), .T_INC_LOW(ILO),
    .T_INC_HIGH(IHI), .T_CYC(CYC), .T_DIR_HOLD(DHO), .T_PRE_DESEL(PRE),
    .T_STORE_WAIT(SWT), .T_NOSTORE_WAIT(NSW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready), .cmd_up_i(up),
    .cmd_steps_i(steps), .cmd_store_i(store), .done_o(done), .cs_no(cs_n), .inc_o(inc),
    .dir_o(dir), .pos_o(pos)
  );

  int checks = 0, failures = 0, cyc = 0;
  int tf[32], tr[32];
  int nf, nr, t_csf, t_csr, t_done, t_rearm, ndone, busy_ready, dir_chg, ncs_edges, dir_at_sel;
  logic p_cs = 1, p_inc = 1, p_done = 0, p_dir = 0;
  int model = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (p_cs != cs_n) ncs_edges++;
    if (p_cs && !cs_n) begin t_csf = cyc; dir_at_sel = int'(dir); end
    if (!p_cs && cs_n) t_csr = cyc;
    if (p_inc && !inc && nf < 32) begin tf[nf] = cyc; nf++; end
    if (!p_inc && inc) begin
      if (!cs_n && nr < 32) begin tr[nr] = cyc; nr++; end
      else if (cs_n) t_rearm = cyc;
    end
    if (done) begin ndone++; if (!p_done) t_done = cyc; end
    if (!cs_n && ready) busy_ready++;
    if (!cs_n && !p_cs && dir != p_dir) dir_chg++;
    p_cs = cs_n; p_inc = inc; p_done = done; p_dir = dir;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input bit u, input int n, input bit s);
    @(negedge clk);
    chk("R1 ready idle", int'(ready), 1);
    nf = 0; nr = 0; t_csf = -1; t_csr = -1; t_done = -1; t_rearm = -1;
    ndone = 0; busy_ready = 0; dir_chg = 0; ncs_edges = 0; dir_at_sel = -1;
    up = u; steps = SW'(n); store = s; valid = 1;
    @(negedge clk);
    valid = 0;
    while (ndone == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (u) model = (model < PMAX) ? model + 1 : PMAX;
      else   model = (model > 0) ? model - 1 : 0;
    end
    chk("R8 done once", ndone, 1);
    chk("R1 ready low busy", busy_ready, 0);
    chk("R9 position", int'(pos), model);
    chk("R3 fall count", nf, n);
    if (n == 0 && !s) begin
      chk("R7 no cs edge", ncs_edges, 0);
    end else begin
      chk("R2 dir value", dir_at_sel, int'(u));
      chk("R2 dir held", dir_chg, 0);
      if (n > 0) chk("R2 select setup", tf[0] - t_csf, SEL);
      for (int i = 0; i < nr; i++) chk("R3 low width", tr[i] - tf[i], ILO);
      for (int i = 0; i + 1 < nf; i++) chk("R3 high width", tf[i+1] - tr[i], HI);
      if (s) begin
        if (n > 0) begin
          chk("R4 rise count", nr, n);
          chk("R4 pre deselect", t_csr - tr[n-1], HI + PRE);
        end else begin
          chk("R6 select span", t_csr - t_csf, SEL + PRE);
        end
        chk(n > 0 ? "R4 store wait" : "R6 store wait", t_done - t_csr, SWT);
      end else begin
        chk("R5 rise count", nr, n - 1);
        chk("R5 last low", t_csr - tf[n-1], LLOW);
        chk("R5 rearm", t_rearm - t_csr, NSW);
        chk("R5 done", t_done - t_rearm, REARM);
      end
    end
  endtask

  initial begin
    #(20 * 150_000);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs", int'(cs_n), 1);
    chk("R1 reset inc", int'(inc), 1);
    chk("R8 reset done", int'(done), 0);
    chk("R9 reset pos", int'(pos), 0);
    rst_n = 1;
    run(1'b0, 3, 1'b0);  // clamp at zero
    for (int s = 1; s >= 0; s--)
      for (int u = 1; u >= 0; u--)
        for (int n = 0; n < 16; n++)
          run(u[0], n, s[0]);
    run(1'b1, 15, 1'b1); // saturate top
    run(1'b1, 2, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule